// File: doc/BRIEF.md
# Basic Block Input/Output Recorder

This block watches the stream of committed instructions and builds one history entry for the basic block that is running now. Each committed instruction presents up to two source registers with their values. It may also present a destination register with its value and a flag from the compiler that says the destination is dead. A load or a store adds an address, the data and the PC of the instruction. While the block runs, the recorder sorts what it sees into four sets. The register inputs are the values the block reads from outside itself. The register outputs are the live values the block produces. The memory inputs are loads that the block does not feed itself. The memory outputs are all stores.

The recorder tells the block's own products apart from outside inputs with one output mask bit per logical register and an address check against the memory outputs already held. Each set fills its slots in arrival order. When an instruction that ends the block commits, the completed entry appears on the outputs with a one-cycle valid pulse. The entry carries the block's start address and the address of the block that follows, and recording of the next block starts from empty state. If any set runs out of slots, the entry is flagged as not reusable, so a later lookup never matches it. Searching the history table and skipping blocks are done elsewhere.

Top module: `bb_io_recorder`

## Requirements
- R1: A source read of a register that has neither its output mask bit nor its input mask bit set takes the next free register-input slot (slot i in bits [i*W +: W] of each flat field, slots filling from 0 upward) with the register number and value, and sets that register's bit in the input mask.
- R2: A source read of a register whose output mask bit is set, because the register was written live earlier in the block, takes no input slot and leaves the input mask unchanged.
- R3: A destination flagged dead takes no output slot and leaves the output mask unchanged.
- R4: A live destination write to a register not yet in the output mask takes the next free output slot. A later live write to the same register overwrites that slot's value and takes no new slot.
- R5: Each load that is not served by a held store takes the next memory-input slot, holding the instruction's PC, the address and the data, and sets that slot's full bit.
- R6: A load whose address equals that of a full memory-output slot takes no memory-input slot.
- R7: Every store takes the next memory-output slot, holding its PC, address and data, and sets that slot's full bit.
- R8: When an item needs a slot and its slot array is full, the completed entry has ent_reusable at 0. A block that does not overflow has ent_reusable at 1.
- R9: One cycle after an instruction with ci_blk_end commits, ent_valid is 1 for exactly one cycle. The entry includes that instruction's effects, the PC of the block's first instruction and ci_next_pc. The next block starts with empty masks and slots.
- R10: After reset, ent_valid, ent_reusable, every mask and every full bit are 0.
- R11: Within one instruction the sources are read before the destination is written, so a register that is both read and written counts as an input and as an output.
- R12: A register read several times from outside the block, in one instruction or in several, takes a single input slot holding the first value read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ci_valid | input | 1 | A committed instruction is presented this cycle |
| ci_pc | input | AW | PC of the committed instruction |
| ci_src_en | input | NSRC | Per-source read enable |
| ci_src_reg | input | NSRC*RW | Source register numbers, source s at [s*RW +: RW] |
| ci_src_val | input | NSRC*DW | Source values, source s at [s*DW +: DW] |
| ci_dst_en | input | 1 | Instruction writes a destination register |
| ci_dst_reg | input | RW | Destination register number |
| ci_dst_val | input | DW | Destination value |
| ci_dst_dead | input | 1 | Compiler marks the destination dead |
| ci_ld_en | input | 1 | Instruction is a load |
| ci_st_en | input | 1 | Instruction is a store |
| ci_mem_addr | input | AW | Memory address of the load or store |
| ci_mem_data | input | DW | Data loaded or stored |
| ci_blk_end | input | 1 | Instruction ends the basic block |
| ci_next_pc | input | AW | Start address of the following block |
| ent_valid | output | 1 | One-cycle pulse: completed entry is on the outputs |
| ent_reusable | output | 1 | Entry had no slot overflow |
| ent_start_pc | output | AW | Start address of the recorded block |
| ent_next_pc | output | AW | Start address of the following block |
| ent_rin_mask | output | NREG | Register input mask |
| ent_rin_full | output | NRIN | Register input slot full bits |
| ent_rin_reg | output | NRIN*RW | Register input slot numbers |
| ent_rin_val | output | NRIN*DW | Register input slot values |
| ent_rout_mask | output | NREG | Live register output mask |
| ent_rout_full | output | NROUT | Register output slot full bits |
| ent_rout_reg | output | NROUT*RW | Register output slot numbers |
| ent_rout_val | output | NROUT*DW | Register output slot values |
| ent_min_full | output | NMIN | Memory input slot full bits |
| ent_min_pc | output | NMIN*AW | Memory input slot PCs |
| ent_min_addr | output | NMIN*AW | Memory input slot addresses |
| ent_min_data | output | NMIN*DW | Memory input slot data |
| ent_mout_full | output | NMOUT | Memory output slot full bits |
| ent_mout_pc | output | NMOUT*AW | Memory output slot PCs |
| ent_mout_addr | output | NMOUT*AW | Memory output slot addresses |
| ent_mout_data | output | NMOUT*DW | Memory output slot data |

## Verification
The bench builds the recorder with its default parameters: 32 logical registers, 32-bit data and addresses, two sources per instruction, and 4, 5, 4 and 2 slots. Because the memory-output array holds only two slots, three stores are enough to reach memory overflow. Five distinct outside reads exhaust the register-input slots inside a block of three instructions. With two sources per instruction, a single instruction can show duplicate reads and a read followed by a write of the same register, and the short blocks that follow each other show that no state carries over from one block to the next.

// File: rtl/bbr_pkg.sv
package bbr_pkg;
  localparam int DEF_NREG  = 32;
  localparam int DEF_DW    = 32;
  localparam int DEF_AW    = 32;
  localparam int DEF_NSRC  = 2;
  localparam int DEF_NRIN  = 4;
  localparam int DEF_NROUT = 5;
  localparam int DEF_NMIN  = 4;
  localparam int DEF_NMOUT = 2;

  // Thermometer code: the lowest n bits set.
  function automatic logic [31:0] therm(input int unsigned n);
    if (n >= 32) return '1;
    return (32'd1 << n) - 32'd1;
  endfunction
endpackage

// File: rtl/bbr_reg_track.sv
module bbr_reg_track #(
  parameter int NREG = bbr_pkg::DEF_NREG,
  parameter int DW   = bbr_pkg::DEF_DW,
  parameter int NSRC = bbr_pkg::DEF_NSRC,
  parameter int NIN  = bbr_pkg::DEF_NRIN,
  parameter int NOUT = bbr_pkg::DEF_NROUT,
  localparam int RW  = $clog2(NREG),
  localparam int ICW = $clog2(NIN + 1),
  localparam int OCW = $clog2(NOUT + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic                 close,
  input  logic [NSRC-1:0]      src_en,
  input  logic [NSRC*RW-1:0]   src_reg,
  input  logic [NSRC*DW-1:0]   src_val,
  input  logic                 dst_en,
  input  logic [RW-1:0]        dst_reg,
  input  logic [DW-1:0]        dst_val,
  input  logic                 dst_dead,
  output logic                 ovf,
  output logic [NREG-1:0]      ent_in_mask,
  output logic [NIN-1:0]       ent_in_full,
  output logic [NIN*RW-1:0]    ent_in_reg,
  output logic [NIN*DW-1:0]    ent_in_val,
  output logic [NREG-1:0]      ent_out_mask,
  output logic [NOUT-1:0]      ent_out_full,
  output logic [NOUT*RW-1:0]   ent_out_reg,
  output logic [NOUT*DW-1:0]   ent_out_val
);
  // accumulated state of the running block
  logic [NREG-1:0] in_mask_q, out_mask_q;
  logic [ICW-1:0]  in_cnt_q;
  logic [OCW-1:0]  out_cnt_q;
  logic [RW-1:0]   in_reg_q  [NIN];
  logic [DW-1:0]   in_val_q  [NIN];
  logic [RW-1:0]   out_reg_q [NOUT];
  logic [DW-1:0]   out_val_q [NOUT];

  // state after the current instruction
  logic [NREG-1:0] in_mask_a, out_mask_a;
  logic [ICW-1:0]  in_cnt_a;
  logic [OCW-1:0]  out_cnt_a;
  logic [RW-1:0]   in_reg_a  [NIN];
  logic [DW-1:0]   in_val_a  [NIN];
  logic [RW-1:0]   out_reg_a [NOUT];
  logic [DW-1:0]   out_val_a [NOUT];

  // captured entry
  logic [NREG-1:0] e_in_mask_q, e_out_mask_q;
  logic [ICW-1:0]  e_in_cnt_q;
  logic [OCW-1:0]  e_out_cnt_q;
  logic [RW-1:0]   e_in_reg_q  [NIN];
  logic [DW-1:0]   e_in_val_q  [NIN];
  logic [RW-1:0]   e_out_reg_q [NOUT];
  logic [DW-1:0]   e_out_val_q [NOUT];

  always_comb begin
    logic [RW-1:0] sr;
    logic          placed;
    in_mask_a  = in_mask_q;
    in_cnt_a   = in_cnt_q;
    in_reg_a   = in_reg_q;
    in_val_a   = in_val_q;
    out_mask_a = out_mask_q;
    out_cnt_a  = out_cnt_q;
    out_reg_a  = out_reg_q;
    out_val_a  = out_val_q;
    ovf        = 1'b0;
    sr         = '0;
    placed     = 1'b0;
    // sources first: an input only if not produced inside the block
    for (int s = 0; s < NSRC; s++) begin
      sr = src_reg[s*RW +: RW];
      if (step && src_en[s] && !out_mask_q[sr] && !in_mask_a[sr]) begin
        placed = 1'b0;
        for (int k = 0; k < NIN; k++) begin
          if (!placed && ICW'(k) == in_cnt_a) begin
            in_reg_a[k] = sr;
            in_val_a[k] = src_val[s*DW +: DW];
            placed      = 1'b1;
          end
        end
        if (placed) begin
          in_mask_a[sr] = 1'b1;
          in_cnt_a      = in_cnt_a + 1'b1;
        end else begin
          ovf = 1'b1;
        end
      end
    end
    // destination after sources; dead results are dropped
    if (step && dst_en && !dst_dead) begin
      if (out_mask_q[dst_reg]) begin
        for (int j = 0; j < NOUT; j++) begin
          if (OCW'(j) < out_cnt_q && out_reg_q[j] == dst_reg) out_val_a[j] = dst_val;
        end
      end else begin
        placed = 1'b0;
        for (int j = 0; j < NOUT; j++) begin
          if (!placed && OCW'(j) == out_cnt_q) begin
            out_reg_a[j] = dst_reg;
            out_val_a[j] = dst_val;
            placed       = 1'b1;
          end
        end
        if (placed) begin
          out_mask_a[dst_reg] = 1'b1;
          out_cnt_a           = out_cnt_q + 1'b1;
        end else begin
          ovf = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_mask_q  <= '0;
      out_mask_q <= '0;
      in_cnt_q   <= '0;
      out_cnt_q  <= '0;
      for (int k = 0; k < NIN; k++) begin
        in_reg_q[k] <= '0;
        in_val_q[k] <= '0;
      end
      for (int j = 0; j < NOUT; j++) begin
        out_reg_q[j] <= '0;
        out_val_q[j] <= '0;
      end
    end else if (close) begin
      in_mask_q  <= '0;
      out_mask_q <= '0;
      in_cnt_q   <= '0;
      out_cnt_q  <= '0;
    end else if (step) begin
      in_mask_q  <= in_mask_a;
      out_mask_q <= out_mask_a;
      in_cnt_q   <= in_cnt_a;
      out_cnt_q  <= out_cnt_a;
      in_reg_q   <= in_reg_a;
      in_val_q   <= in_val_a;
      out_reg_q  <= out_reg_a;
      out_val_q  <= out_val_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_in_mask_q  <= '0;
      e_out_mask_q <= '0;
      e_in_cnt_q   <= '0;
      e_out_cnt_q  <= '0;
      for (int k = 0; k < NIN; k++) begin
        e_in_reg_q[k] <= '0;
        e_in_val_q[k] <= '0;
      end
      for (int j = 0; j < NOUT; j++) begin
        e_out_reg_q[j] <= '0;
        e_out_val_q[j] <= '0;
      end
    end else if (close) begin
      e_in_mask_q  <= in_mask_a;
      e_out_mask_q <= out_mask_a;
      e_in_cnt_q   <= in_cnt_a;
      e_out_cnt_q  <= out_cnt_a;
      e_in_reg_q   <= in_reg_a;
      e_in_val_q   <= in_val_a;
      e_out_reg_q  <= out_reg_a;
      e_out_val_q  <= out_val_a;
    end
  end

  assign ent_in_mask  = e_in_mask_q;
  assign ent_out_mask = e_out_mask_q;
  assign ent_in_full  = NIN'(bbr_pkg::therm(32'(e_in_cnt_q)));
  assign ent_out_full = NOUT'(bbr_pkg::therm(32'(e_out_cnt_q)));

  for (genvar g = 0; g < NIN; g++) begin : g_in
    assign ent_in_reg[g*RW +: RW] = e_in_reg_q[g];
    assign ent_in_val[g*DW +: DW] = e_in_val_q[g];
  end
  for (genvar g = 0; g < NOUT; g++) begin : g_out
    assign ent_out_reg[g*RW +: RW] = e_out_reg_q[g];
    assign ent_out_val[g*DW +: DW] = e_out_val_q[g];
  end
endmodule

// File: rtl/bbr_mem_track.sv
module bbr_mem_track #(
  parameter int AW   = bbr_pkg::DEF_AW,
  parameter int DW   = bbr_pkg::DEF_DW,
  parameter int NIN  = bbr_pkg::DEF_NMIN,
  parameter int NOUT = bbr_pkg::DEF_NMOUT,
  localparam int ICW = $clog2(NIN + 1),
  localparam int OCW = $clog2(NOUT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic               close,
  input  logic [AW-1:0]      pc,
  input  logic               ld_en,
  input  logic               st_en,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      data,
  output logic               ovf,
  output logic [NIN-1:0]     ent_in_full,
  output logic [NIN*AW-1:0]  ent_in_pc,
  output logic [NIN*AW-1:0]  ent_in_addr,
  output logic [NIN*DW-1:0]  ent_in_data,
  output logic [NOUT-1:0]    ent_out_full,
  output logic [NOUT*AW-1:0] ent_out_pc,
  output logic [NOUT*AW-1:0] ent_out_addr,
  output logic [NOUT*DW-1:0] ent_out_data
);
  logic [ICW-1:0] in_cnt_q, in_cnt_a, e_in_cnt_q;
  logic [OCW-1:0] out_cnt_q, out_cnt_a, e_out_cnt_q;
  logic [AW-1:0]  in_pc_q [NIN],  in_addr_q [NIN],  in_pc_a [NIN],  in_addr_a [NIN];
  logic [DW-1:0]  in_data_q [NIN], in_data_a [NIN];
  logic [AW-1:0]  out_pc_q [NOUT], out_addr_q [NOUT], out_pc_a [NOUT], out_addr_a [NOUT];
  logic [DW-1:0]  out_data_q [NOUT], out_data_a [NOUT];
  logic [AW-1:0]  e_in_pc_q [NIN],  e_in_addr_q [NIN];
  logic [DW-1:0]  e_in_data_q [NIN];
  logic [AW-1:0]  e_out_pc_q [NOUT], e_out_addr_q [NOUT];
  logic [DW-1:0]  e_out_data_q [NOUT];

  always_comb begin
    logic fwd;
    logic placed;
    in_cnt_a   = in_cnt_q;
    in_pc_a    = in_pc_q;
    in_addr_a  = in_addr_q;
    in_data_a  = in_data_q;
    out_cnt_a  = out_cnt_q;
    out_pc_a   = out_pc_q;
    out_addr_a = out_addr_q;
    out_data_a = out_data_q;
    ovf        = 1'b0;
    fwd        = 1'b0;
    placed     = 1'b0;
    // a load fed by a store held in this block is not upward-exposed
    for (int j = 0; j < NOUT; j++) begin
      if (OCW'(j) < out_cnt_q && out_addr_q[j] == addr) fwd = 1'b1;
    end
    if (step && ld_en && !fwd) begin
      for (int k = 0; k < NIN; k++) begin
        if (!placed && ICW'(k) == in_cnt_q) begin
          in_pc_a[k]   = pc;
          in_addr_a[k] = addr;
          in_data_a[k] = data;
          placed       = 1'b1;
        end
      end
      if (placed) in_cnt_a = in_cnt_q + 1'b1;
      else        ovf      = 1'b1;
    end
    placed = 1'b0;
    if (step && st_en) begin
      for (int j = 0; j < NOUT; j++) begin
        if (!placed && OCW'(j) == out_cnt_q) begin
          out_pc_a[j]   = pc;
          out_addr_a[j] = addr;
          out_data_a[j] = data;
          placed        = 1'b1;
        end
      end
      if (placed) out_cnt_a = out_cnt_q + 1'b1;
      else        ovf       = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cnt_q  <= '0;
      out_cnt_q <= '0;
      for (int k = 0; k < NIN; k++) begin
        in_pc_q[k]   <= '0;
        in_addr_q[k] <= '0;
        in_data_q[k] <= '0;
      end
      for (int j = 0; j < NOUT; j++) begin
        out_pc_q[j]   <= '0;
        out_addr_q[j] <= '0;
        out_data_q[j] <= '0;
      end
    end else if (close) begin
      in_cnt_q  <= '0;
      out_cnt_q <= '0;
    end else if (step) begin
      in_cnt_q   <= in_cnt_a;
      out_cnt_q  <= out_cnt_a;
      in_pc_q    <= in_pc_a;
      in_addr_q  <= in_addr_a;
      in_data_q  <= in_data_a;
      out_pc_q   <= out_pc_a;
      out_addr_q <= out_addr_a;
      out_data_q <= out_data_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_in_cnt_q  <= '0;
      e_out_cnt_q <= '0;
      for (int k = 0; k < NIN; k++) begin
        e_in_pc_q[k]   <= '0;
        e_in_addr_q[k] <= '0;
        e_in_data_q[k] <= '0;
      end
      for (int j = 0; j < NOUT; j++) begin
        e_out_pc_q[j]   <= '0;
        e_out_addr_q[j] <= '0;
        e_out_data_q[j] <= '0;
      end
    end else if (close) begin
      e_in_cnt_q   <= in_cnt_a;
      e_out_cnt_q  <= out_cnt_a;
      e_in_pc_q    <= in_pc_a;
      e_in_addr_q  <= in_addr_a;
      e_in_data_q  <= in_data_a;
      e_out_pc_q   <= out_pc_a;
      e_out_addr_q <= out_addr_a;
      e_out_data_q <= out_data_a;
    end
  end

  assign ent_in_full  = NIN'(bbr_pkg::therm(32'(e_in_cnt_q)));
  assign ent_out_full = NOUT'(bbr_pkg::therm(32'(e_out_cnt_q)));

  for (genvar g = 0; g < NIN; g++) begin : g_in
    assign ent_in_pc[g*AW +: AW]   = e_in_pc_q[g];
    assign ent_in_addr[g*AW +: AW] = e_in_addr_q[g];
    assign ent_in_data[g*DW +: DW] = e_in_data_q[g];
  end
  for (genvar g = 0; g < NOUT; g++) begin : g_out
    assign ent_out_pc[g*AW +: AW]   = e_out_pc_q[g];
    assign ent_out_addr[g*AW +: AW] = e_out_addr_q[g];
    assign ent_out_data[g*DW +: DW] = e_out_data_q[g];
  end
endmodule

// File: rtl/bb_io_recorder.sv
module bb_io_recorder #(
  parameter int NREG  = bbr_pkg::DEF_NREG,
  parameter int DW    = bbr_pkg::DEF_DW,
  parameter int AW    = bbr_pkg::DEF_AW,
  parameter int NSRC  = bbr_pkg::DEF_NSRC,
  parameter int NRIN  = bbr_pkg::DEF_NRIN,
  parameter int NROUT = bbr_pkg::DEF_NROUT,
  parameter int NMIN  = bbr_pkg::DEF_NMIN,
  parameter int NMOUT = bbr_pkg::DEF_NMOUT,
  localparam int RW   = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ci_valid,
  input  logic [AW-1:0]         ci_pc,
  input  logic [NSRC-1:0]       ci_src_en,
  input  logic [NSRC*RW-1:0]    ci_src_reg,
  input  logic [NSRC*DW-1:0]    ci_src_val,
  input  logic                  ci_dst_en,
  input  logic [RW-1:0]         ci_dst_reg,
  input  logic [DW-1:0]         ci_dst_val,
  input  logic                  ci_dst_dead,
  input  logic                  ci_ld_en,
  input  logic                  ci_st_en,
  input  logic [AW-1:0]         ci_mem_addr,
  input  logic [DW-1:0]         ci_mem_data,
  input  logic                  ci_blk_end,
  input  logic [AW-1:0]         ci_next_pc,
  output logic                  ent_valid,
  output logic                  ent_reusable,
  output logic [AW-1:0]         ent_start_pc,
  output logic [AW-1:0]         ent_next_pc,
  output logic [NREG-1:0]       ent_rin_mask,
  output logic [NRIN-1:0]       ent_rin_full,
  output logic [NRIN*RW-1:0]    ent_rin_reg,
  output logic [NRIN*DW-1:0]    ent_rin_val,
  output logic [NREG-1:0]       ent_rout_mask,
  output logic [NROUT-1:0]      ent_rout_full,
  output logic [NROUT*RW-1:0]   ent_rout_reg,
  output logic [NROUT*DW-1:0]   ent_rout_val,
  output logic [NMIN-1:0]       ent_min_full,
  output logic [NMIN*AW-1:0]    ent_min_pc,
  output logic [NMIN*AW-1:0]    ent_min_addr,
  output logic [NMIN*DW-1:0]    ent_min_data,
  output logic [NMOUT-1:0]      ent_mout_full,
  output logic [NMOUT*AW-1:0]   ent_mout_pc,
  output logic [NMOUT*AW-1:0]   ent_mout_addr,
  output logic [NMOUT*DW-1:0]   ent_mout_data
);
  logic          step, close;
  logic          reg_ovf, mem_ovf;
  logic          ovf_q, ovf_d;
  logic          in_blk_q, in_blk_d;
  logic [AW-1:0] start_q, start_d;
  logic          ev_q;
  logic          reuse_q;
  logic [AW-1:0] e_start_q, e_next_q;

  assign step  = ci_valid;
  assign close = ci_valid && ci_blk_end;

  bbr_reg_track #(
    .NREG(NREG), .DW(DW), .NSRC(NSRC), .NIN(NRIN), .NOUT(NROUT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .step(step), .close(close),
    .src_en(ci_src_en), .src_reg(ci_src_reg), .src_val(ci_src_val),
    .dst_en(ci_dst_en), .dst_reg(ci_dst_reg), .dst_val(ci_dst_val), .dst_dead(ci_dst_dead),
    .ovf(reg_ovf),
    .ent_in_mask(ent_rin_mask), .ent_in_full(ent_rin_full),
    .ent_in_reg(ent_rin_reg), .ent_in_val(ent_rin_val),
    .ent_out_mask(ent_rout_mask), .ent_out_full(ent_rout_full),
    .ent_out_reg(ent_rout_reg), .ent_out_val(ent_rout_val)
  );

  bbr_mem_track #(
    .AW(AW), .DW(DW), .NIN(NMIN), .NOUT(NMOUT)
  ) u_mem (
    .clk(clk), .rst_n(rst_n), .step(step), .close(close),
    .pc(ci_pc), .ld_en(ci_ld_en), .st_en(ci_st_en),
    .addr(ci_mem_addr), .data(ci_mem_data),
    .ovf(mem_ovf),
    .ent_in_full(ent_min_full), .ent_in_pc(ent_min_pc),
    .ent_in_addr(ent_min_addr), .ent_in_data(ent_min_data),
    .ent_out_full(ent_mout_full), .ent_out_pc(ent_mout_pc),
    .ent_out_addr(ent_mout_addr), .ent_out_data(ent_mout_data)
  );

  // next-state for block framing and overflow
  always_comb begin
    ovf_d    = ovf_q || reg_ovf || mem_ovf;
    start_d  = in_blk_q ? start_q : ci_pc;
    in_blk_d = in_blk_q;
    if (close)     in_blk_d = 1'b0;
    else if (step) in_blk_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q    <= 1'b0;
      in_blk_q <= 1'b0;
      start_q  <= '0;
    end else if (step) begin
      ovf_q    <= close ? 1'b0 : ovf_d;
      in_blk_q <= in_blk_d;
      start_q  <= start_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q      <= 1'b0;
      reuse_q   <= 1'b0;
      e_start_q <= '0;
      e_next_q  <= '0;
    end else begin
      ev_q <= close;
      if (close) begin
        reuse_q   <= !ovf_d;
        e_start_q <= start_d;
        e_next_q  <= ci_next_pc;
      end
    end
  end

  assign ent_valid    = ev_q;
  assign ent_reusable = reuse_q;
  assign ent_start_pc = e_start_q;
  assign ent_next_pc  = e_next_q;
endmodule

// File: rtl/bbr_chk.sv
module bbr_chk #(
  parameter int NREG  = bbr_pkg::DEF_NREG,
  parameter int AW    = bbr_pkg::DEF_AW,
  parameter int NRIN  = bbr_pkg::DEF_NRIN,
  parameter int NROUT = bbr_pkg::DEF_NROUT
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ci_valid,
  input logic             ci_blk_end,
  input logic [AW-1:0]    ci_next_pc,
  input logic             ent_valid,
  input logic             ent_reusable,
  input logic [AW-1:0]    ent_start_pc,
  input logic [AW-1:0]    ent_next_pc,
  input logic [NREG-1:0]  ent_rin_mask,
  input logic [NRIN-1:0]  ent_rin_full,
  input logic [NREG-1:0]  ent_rout_mask,
  input logic [NROUT-1:0] ent_rout_full
);
  AST_PULSE_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    (ci_valid && ci_blk_end) |=> ent_valid);  // R9
  AST_NO_STRAY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ci_valid && ci_blk_end) |=> !ent_valid);  // R9
  AST_NEXT_PC_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    (ci_valid && ci_blk_end) |=> (ent_next_pc == $past(ci_next_pc)));  // R9
  AST_ENTRY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !ent_valid |-> $stable(ent_start_pc));  // R9
  AST_RIN_MASK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && ent_reusable) |-> ($countones(ent_rin_mask) == $countones(ent_rin_full)));  // R1
  AST_ROUT_MASK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && ent_reusable) |-> ($countones(ent_rout_mask) == $countones(ent_rout_full)));  // R4
endmodule

bind bb_io_recorder bbr_chk #(
  .NREG(NREG), .AW(AW), .NRIN(NRIN), .NROUT(NROUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ci_valid(ci_valid), .ci_blk_end(ci_blk_end),
  .ci_next_pc(ci_next_pc), .ent_valid(ent_valid), .ent_reusable(ent_reusable),
  .ent_start_pc(ent_start_pc), .ent_next_pc(ent_next_pc),
  .ent_rin_mask(ent_rin_mask), .ent_rin_full(ent_rin_full),
  .ent_rout_mask(ent_rout_mask), .ent_rout_full(ent_rout_full)
);

// File: tb/bb_io_recorder_bench.sv
module bb_io_recorder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 32, RW = 5, DW = 32, AW = 32, NSRC = 2;
  localparam int NRIN = 4, NROUT = 5, NMIN = 4, NMOUT = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic ci_valid, ci_dst_en, ci_dst_dead, ci_ld_en, ci_st_en, ci_blk_end;
  logic [AW-1:0] ci_pc, ci_mem_addr, ci_next_pc;
  logic [NSRC-1:0] ci_src_en;
  logic [NSRC*RW-1:0] ci_src_reg;
  logic [NSRC*DW-1:0] ci_src_val;
  logic [RW-1:0] ci_dst_reg;
  logic [DW-1:0] ci_dst_val, ci_mem_data;
  logic ent_valid, ent_reusable;
  logic [AW-1:0] ent_start_pc, ent_next_pc;
  logic [NREG-1:0] ent_rin_mask, ent_rout_mask;
  logic [NRIN-1:0] ent_rin_full;
  logic [NRIN*RW-1:0] ent_rin_reg;
  logic [NRIN*DW-1:0] ent_rin_val;
  logic [NROUT-1:0] ent_rout_full;
  logic [NROUT*RW-1:0] ent_rout_reg;
  logic [NROUT*DW-1:0] ent_rout_val;
  logic [NMIN-1:0] ent_min_full;
  logic [NMIN*AW-1:0] ent_min_pc, ent_min_addr;
  logic [NMIN*DW-1:0] ent_min_data;
  logic [NMOUT-1:0] ent_mout_full;
  logic [NMOUT*AW-1:0] ent_mout_pc, ent_mout_addr;
  logic [NMOUT*DW-1:0] ent_mout_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bb_io_recorder u_bb_io_recorder (
    .clk(clk), .rst_n(rst_n), .ci_valid(ci_valid), .ci_pc(ci_pc),
    .ci_src_en(ci_src_en), .ci_src_reg(ci_src_reg), .ci_src_val(ci_src_val),
    .ci_dst_en(ci_dst_en), .ci_dst_reg(ci_dst_reg), .ci_dst_val(ci_dst_val),
    .ci_dst_dead(ci_dst_dead), .ci_ld_en(ci_ld_en), .ci_st_en(ci_st_en),
    .ci_mem_addr(ci_mem_addr), .ci_mem_data(ci_mem_data),
    .ci_blk_end(ci_blk_end), .ci_next_pc(ci_next_pc),
    .ent_valid(ent_valid), .ent_reusable(ent_reusable),
    .ent_start_pc(ent_start_pc), .ent_next_pc(ent_next_pc),
    .ent_rin_mask(ent_rin_mask), .ent_rin_full(ent_rin_full),
    .ent_rin_reg(ent_rin_reg), .ent_rin_val(ent_rin_val),
    .ent_rout_mask(ent_rout_mask), .ent_rout_full(ent_rout_full),
    .ent_rout_reg(ent_rout_reg), .ent_rout_val(ent_rout_val),
    .ent_min_full(ent_min_full), .ent_min_pc(ent_min_pc),
    .ent_min_addr(ent_min_addr), .ent_min_data(ent_min_data),
    .ent_mout_full(ent_mout_full), .ent_mout_pc(ent_mout_pc),
    .ent_mout_addr(ent_mout_addr), .ent_mout_data(ent_mout_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ci_valid = 0; ci_pc = '0; ci_src_en = '0; ci_src_reg = '0; ci_src_val = '0;
    ci_dst_en = 0; ci_dst_reg = '0; ci_dst_val = '0; ci_dst_dead = 0;
    ci_ld_en = 0; ci_st_en = 0; ci_mem_addr = '0; ci_mem_data = '0;
    ci_blk_end = 0; ci_next_pc = '0;
  endtask

  task automatic ins(input logic [AW-1:0] pc);
    ci_valid = 1; ci_pc = pc;
  endtask
  task automatic rd(input int i, input int r, input logic [DW-1:0] v);
    ci_src_en[i] = 1'b1;
    ci_src_reg[i*RW +: RW] = RW'(r);
    ci_src_val[i*DW +: DW] = v;
  endtask
  task automatic wr(input int r, input logic [DW-1:0] v, input logic dead);
    ci_dst_en = 1; ci_dst_reg = RW'(r); ci_dst_val = v; ci_dst_dead = dead;
  endtask
  task automatic ld(input logic [AW-1:0] a, input logic [DW-1:0] d);
    ci_ld_en = 1; ci_mem_addr = a; ci_mem_data = d;
  endtask
  task automatic st(input logic [AW-1:0] a, input logic [DW-1:0] d);
    ci_st_en = 1; ci_mem_addr = a; ci_mem_data = d;
  endtask
  task automatic fin(input logic [AW-1:0] npc);
    ci_blk_end = 1; ci_next_pc = npc;
  endtask
  // commit the driven instruction: one posedge passes, back at a negedge
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    chk("R10 valid", 64'(ent_valid), 64'd0);
    chk("R10 reusable", 64'(ent_reusable), 64'd0);
    chk("R10 masks", 64'(ent_rin_mask | ent_rout_mask), 64'd0);
    chk("R10 full bits", 64'({ent_rin_full, ent_rout_full, ent_min_full, ent_mout_full}), 64'd0);
  endtask

  task automatic t_registers();
    ins(32'h100); rd(0, 3, 32'd11); rd(1, 4, 32'd22); wr(5, 32'd33, 1'b0); step();
    ins(32'h104); rd(0, 5, 32'd33); rd(1, 3, 32'd99); wr(6, 32'd44, 1'b1); step();
    ins(32'h108); rd(0, 4, 32'd77); wr(5, 32'd55, 1'b0); fin(32'h200); step();
    chk("R9 pulse", 64'(ent_valid), 64'd1);
    chk("R9 start pc", 64'(ent_start_pc), 64'h100);
    chk("R9 next pc", 64'(ent_next_pc), 64'h200);
    chk("R8 reusable", 64'(ent_reusable), 64'd1);
    chk("R1 rin full", 64'(ent_rin_full), 64'b0011);
    chk("R1 slot0 reg", 64'(ent_rin_reg[0 +: RW]), 64'd3);
    chk("R12 slot0 first value", 64'(ent_rin_val[0 +: DW]), 64'd11);
    chk("R1 slot1 reg", 64'(ent_rin_reg[RW +: RW]), 64'd4);
    chk("R12 slot1 first value", 64'(ent_rin_val[DW +: DW]), 64'd22);
    chk("R2 rin mask", 64'(ent_rin_mask), 64'h18);
    chk("R3 rout mask", 64'(ent_rout_mask), 64'h20);
    chk("R4 rout full", 64'(ent_rout_full), 64'b00001);
    chk("R4 slot0 reg", 64'(ent_rout_reg[0 +: RW]), 64'd5);
    chk("R4 slot0 overwritten", 64'(ent_rout_val[0 +: DW]), 64'd55);
    step();
    chk("R9 pulse one cycle", 64'(ent_valid), 64'd0);
    chk("R9 entry held", 64'(ent_start_pc), 64'h100);
  endtask

  task automatic t_same_instr();
    ins(32'h300); rd(0, 7, 32'd5); rd(1, 7, 32'd5); wr(7, 32'd6, 1'b0); fin(32'h304); step();
    chk("R9 pulse", 64'(ent_valid), 64'd1);
    chk("R9 clean restart rin", 64'(ent_rin_full), 64'b0001);
    chk("R11 input reg", 64'(ent_rin_reg[0 +: RW]), 64'd7);
    chk("R11 input val", 64'(ent_rin_val[0 +: DW]), 64'd5);
    chk("R11 output val", 64'(ent_rout_val[0 +: DW]), 64'd6);
    chk("R12 one slot in mask", 64'(ent_rin_mask), 64'h80);
    chk("R9 single start pc", 64'(ent_start_pc), 64'h300);
  endtask

  task automatic t_memory();
    ins(32'h400); st(32'h1000, 32'd9); step();
    ins(32'h404); ld(32'h1000, 32'd9); step();
    ins(32'h408); ld(32'h2000, 32'd7); step();
    ins(32'h40c); ld(32'h3000, 32'd8); fin(32'h500); step();
    chk("R9 pulse", 64'(ent_valid), 64'd1);
    chk("R7 mout full", 64'(ent_mout_full), 64'b01);
    chk("R7 mout pc", 64'(ent_mout_pc[0 +: AW]), 64'h400);
    chk("R7 mout addr", 64'(ent_mout_addr[0 +: AW]), 64'h1000);
    chk("R7 mout data", 64'(ent_mout_data[0 +: DW]), 64'd9);
    chk("R6 forwarded load skipped", 64'(ent_min_full), 64'b0011);
    chk("R5 min0 pc", 64'(ent_min_pc[0 +: AW]), 64'h408);
    chk("R5 min0 addr", 64'(ent_min_addr[0 +: AW]), 64'h2000);
    chk("R5 min1 pc", 64'(ent_min_pc[AW +: AW]), 64'h40c);
    chk("R5 min1 data", 64'(ent_min_data[DW +: DW]), 64'd8);
    chk("R9 no register carryover", 64'(ent_rin_full | ent_rout_full), 64'd0);
  endtask

  task automatic t_reg_overflow();
    ins(32'h600); rd(0, 1, 32'd1); rd(1, 2, 32'd2); step();
    ins(32'h604); rd(0, 8, 32'd3); rd(1, 9, 32'd4); step();
    ins(32'h608); rd(0, 10, 32'd5); fin(32'h700); step();
    chk("R8 rin overflow not reusable", 64'(ent_reusable), 64'd0);
    chk("R8 rin all full", 64'(ent_rin_full), 64'b1111);
  endtask

  task automatic t_mem_overflow();
    ins(32'h800); st(32'h10, 32'd1); step();
    ins(32'h804); st(32'h20, 32'd2); step();
    ins(32'h808); st(32'h30, 32'd3); fin(32'h900); step();
    chk("R8 mout overflow not reusable", 64'(ent_reusable), 64'd0);
    chk("R7 mout all full", 64'(ent_mout_full), 64'b11);
    ins(32'ha00); fin(32'ha10); step();
    chk("R8 overflow cleared next block", 64'(ent_reusable), 64'd1);
    chk("R9 empty block start", 64'(ent_start_pc), 64'ha00);
    chk("R9 empty block slots", 64'({ent_rin_full, ent_rout_full, ent_min_full, ent_mout_full}), 64'd0);
  endtask

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_registers();
    t_same_instr();
    t_memory();
    t_reg_overflow();
    t_mem_overflow();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule